// File: doc/BRIEF.md
# Byte-Parallel Ethernet Frame Check Sequence Verifier

This block checks the 32-bit frame check sequence of Ethernet frames that arrive one byte per clock. A start-of-frame pulse seeds the checksum register with all ones. Every byte accepted while data-valid is high moves the register forward by eight CRC steps, all within one clock. The bits of each byte enter least significant first, which is the order they have on the wire. When a byte is flagged as the end of the frame, the block delivers a verdict.

The checksum datapath is a 32-bit register. It is fed by a combinational chain of shift-and-conditional-XOR stages, one stage per input bit. A separate control state machine decides when the register is seeded, when it is enabled, when the frame ends and what the verdict is. The last four bytes of each frame are the transmitted check sequence: the complemented, bit-reflected CRC, least significant byte first. If those bytes are correct, the register ends on a fixed residue. The verdict compares against that residue.

Top module: `eth_fcs_checker`

## Requirements
- R1: While reset is high, and in the first cycle after it, `frame_done_o` and `crc_err_o` are 0 and no frame is active.
- R2: A start-of-frame pulse loads the checksum register with 0xFFFFFFFF. If data-valid is high in the same cycle, that byte is the first byte of the frame.
- R3: Each accepted byte is folded in over eight steps within one clock, least significant bit first. Each step shifts the register left by one with a zero entering, then XORs in 0x04C11DB7 when the input bit differs from the old most significant bit. A frame whose last four bytes are the complemented, bit-reflected CRC-32 of the preceding bytes, least significant byte first, gives `crc_err_o` = 0.
- R4: A cycle with data-valid low leaves the checksum unchanged, whatever is on the data byte. Idle gaps inside a frame do not change the verdict.
- R5: `frame_done_o` is high for exactly one cycle. It comes in the cycle after the clock edge that accepts a byte with data-valid and end-of-frame both high during an active frame.
- R6: The verdict complements the final register value and compares it with the complement of 0xC704DD7B. Any difference sets `crc_err_o` = 1, together with `frame_done_o`. A frame with a corrupted byte therefore reports an error.
- R7: `crc_err_o` holds its value until the next start-of-frame, and that pulse clears it to 0.
- R8: A start-of-frame pulse during an active frame drops the bytes gathered so far. It re-seeds the register, and the verdict covers only the bytes from the new pulse onward.
- R9: End-of-frame or data-valid with no frame active gives no `frame_done_o` and leaves `crc_err_o` unchanged. End-of-frame with data-valid low is ignored.
- R10: If start-of-frame and end-of-frame are high in the same cycle, start-of-frame wins. A new frame begins and no `frame_done_o` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sof_i | input | 1 | Start-of-frame pulse, seeds the checksum |
| data_i | input | 8 | Received byte |
| valid_i | input | 1 | Qualifies `data_i` in this cycle |
| eof_i | input | 1 | Marks the current valid byte as the last byte of the frame |
| frame_done_o | output | 1 | One-cycle strobe, the verdict is ready |
| crc_err_o | output | 1 | 1 when the last frame failed its check, held until the next start |

## Verification
The assertions check, on every cycle, the rules that relate the control signals to the register and the outputs. A seed-only start leaves all ones in the register. An idle cycle leaves it unchanged. The done strobe lasts one cycle and appears only after an accepted end-of-frame. The error flag changes only on a verdict or a start, and a start that meets an end gives no verdict. Whether the eight-step chain computes the right checksum, and whether an abandoned frame's bytes are truly dropped, can only be shown by the bench's scenarios. Those scenarios compare the verdict with a bit-reflected reference CRC computed in the bench over whole frames: gapped, corrupted, restarted, and both short and long.

// File: rtl/eth_fcs_pkg.sv
package eth_fcs_pkg;

    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned SUM_W       = 32;
    localparam logic [31:0] GEN_POLY    = 32'h04C1_1DB7;
    localparam logic [31:0] SEED_VALUE  = 32'hFFFF_FFFF;
    localparam logic [31:0] GOOD_RESID  = 32'hC704_DD7B;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BODY = 1'b1
    } frame_state_e;

    typedef struct packed {
        logic load;
        logic adv;
    } sum_ctl_t;

    // One serial CRC step: shift left with a zero in, then conditional XOR of the polynomial.
    function automatic logic [SUM_W-1:0] crc_bit_step(
        input logic [SUM_W-1:0] cur,
        input logic             din,
        input logic [SUM_W-1:0] poly
    );
        logic fb;
        fb = din ^ cur[SUM_W-1];
        return {cur[SUM_W-2:0], 1'b0} ^ (fb ? poly : '0);
    endfunction

endpackage

// File: rtl/crc_lane_engine.sv
module crc_lane_engine
    import eth_fcs_pkg::*;
#(
    parameter int unsigned         DW   = BYTE_W,
    parameter int unsigned         CW   = SUM_W,
    parameter logic [SUM_W-1:0]    POLY = GEN_POLY,
    parameter logic [SUM_W-1:0]    SEED = SEED_VALUE
) (
    input  logic          clk,
    input  logic          rst,
    input  sum_ctl_t      ctl,
    input  logic [DW-1:0] data,
    output logic [CW-1:0] sum_q,
    output logic [CW-1:0] sum_nxt
);

    logic [CW-1:0] chain [0:DW];

    // The base of the chain is the seed on a start, else the stored sum.
    assign chain[0] = ctl.load ? SEED[CW-1:0] : sum_q;

    // Unrolled bit steps, least significant input bit first.
    for (genvar g = 0; g < DW; g++) begin : g_step
        assign chain[g+1] = crc_bit_step(chain[g], data[g], POLY[CW-1:0]);
    end

    assign sum_nxt = ctl.adv ? chain[DW] : chain[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= SEED[CW-1:0];
        end else if (ctl.load || ctl.adv) begin
            sum_q <= sum_nxt;
        end
    end

    // A start with no data leaves exactly the seed.
    assert_seed_load_R2: assert property (@(posedge clk) disable iff (rst)
        $past(ctl.load && !ctl.adv) |-> sum_q == SEED[CW-1:0]);

    // With neither seed nor advance, the checksum holds.
    assert_hold_on_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(ctl.load) && !$past(ctl.adv)) |-> $stable(sum_q));

endmodule

// File: rtl/crc_residue_cmp.sv
module crc_residue_cmp
    import eth_fcs_pkg::*;
#(
    parameter int unsigned      CW    = SUM_W,
    parameter logic [SUM_W-1:0] RESID = GOOD_RESID
) (
    input  logic [CW-1:0] sum_val,
    output logic          mismatch
);

    localparam logic [CW-1:0] FINAL_GOOD = ~RESID[CW-1:0];

    logic [CW-1:0] final_val;

    // The remainder is complemented before the comparison.
    assign final_val = ~sum_val;
    assign mismatch  = (final_val != FINAL_GOOD);

endmodule

// File: rtl/crc_frame_ctrl.sv
module crc_frame_ctrl
    import eth_fcs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sof,
    input  logic     vld,
    input  logic     eof,
    input  logic     mismatch,
    output sum_ctl_t ctl,
    output logic     done,
    output logic     err
);

    frame_state_e state_q, state_d;
    logic         in_frame;
    logic         last_byte;

    assign in_frame  = (state_q == ST_BODY);
    assign last_byte = in_frame && vld && eof && !sof;

    assign ctl.load = sof;
    assign ctl.adv  = vld && (sof || in_frame);

    always_comb begin
        state_d = state_q;
        if (sof) begin
            state_d = ST_BODY;
        end else if (last_byte) begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= last_byte;
            if (sof) begin
                err <= 1'b0;
            end else if (last_byte) begin
                err <= mismatch;
            end
        end
    end

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_cause_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(in_frame && vld && eof && !sof));

    assert_err_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(sof) && !done) |-> $stable(err));

    assert_sof_clears_R7: assert property (@(posedge clk) disable iff (rst)
        sof |=> !err);

    assert_sof_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (sof && eof) |=> !done);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!in_frame && !sof) |=> !done);

endmodule

// File: rtl/eth_fcs_checker.sv
module eth_fcs_checker
    import eth_fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sof_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              valid_i,
    input  logic              eof_i,
    output logic              frame_done_o,
    output logic              crc_err_o
);

    sum_ctl_t         ctl;
    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] sum_nxt;
    logic             mismatch;

    crc_frame_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sof      (sof_i),
        .vld      (valid_i),
        .eof      (eof_i),
        .mismatch (mismatch),
        .ctl      (ctl),
        .done     (frame_done_o),
        .err      (crc_err_o)
    );

    crc_lane_engine #(
        .DW   (BYTE_W),
        .CW   (SUM_W),
        .POLY (GEN_POLY),
        .SEED (SEED_VALUE)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .data    (data_i),
        .sum_q   (sum_q),
        .sum_nxt (sum_nxt)
    );

    // The verdict looks at the value that includes the final byte.
    crc_residue_cmp #(
        .CW    (SUM_W),
        .RESID (GOOD_RESID)
    ) u_cmp (
        .sum_val  (sum_nxt),
        .mismatch (mismatch)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!frame_done_o && !crc_err_o));

endmodule

// File: tb/test_eth_fcs_checker.sv
module test_eth_fcs_checker;

    logic       clk = 1'b0;
    logic       rst;
    logic       sof_i, valid_i, eof_i;
    logic [7:0] data_i;
    logic       frame_done_o, crc_err_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // Reference model state
    bit         m_active = 0;
    bit         m_done   = 0;
    bit         m_err    = 0;
    byte unsigned m_q[$];

    always #2.5 clk = ~clk;

    eth_fcs_checker i_eth_fcs_checker (
        .clk          (clk),
        .rst          (rst),
        .sof_i        (sof_i),
        .data_i       (data_i),
        .valid_i      (valid_i),
        .eof_i        (eof_i),
        .frame_done_o (frame_done_o),
        .crc_err_o    (crc_err_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Reflected CRC-32 as transmitted in the check sequence.
    function automatic logic [31:0] ref_crc(input byte unsigned b[$], input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c ^= {24'h0, b[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic bit ref_bad(input byte unsigned b[$]);
        int n = b.size();
        logic [31:0] rx;
        if (n < 4) return 1'b1;
        rx = {b[n-1], b[n-2], b[n-3], b[n-4]};
        return ref_crc(b, n - 4) != rx;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Drive one cycle, advance the model, compare after the edge.
    task automatic tick(input bit s, input bit v, input bit e, input byte unsigned d, input string tag);
        sof_i = s; valid_i = v; eof_i = e; data_i = d;
        @(posedge clk);
        m_done = 0;
        if (s) begin
            m_active = 1; m_q.delete(); m_err = 0;
            if (v) m_q.push_back(d);
        end else if (m_active && v) begin
            m_q.push_back(d);
            if (e) begin
                m_done = 1; m_err = ref_bad(m_q); m_active = 0;
            end
        end
        @(negedge clk);
        check(tag, frame_done_o, m_done, "frame_done");
        check(tag, crc_err_o, m_err, "crc_err");
    endtask

    // Send payload plus its check sequence; optionally flip a byte and insert idle gaps.
    task automatic send(input byte unsigned pl[$], input int flip_at, input bit gaps,
                        input bit sof_alone, input string tag);
        byte unsigned f[$];
        logic [31:0] c;
        f = pl;
        c = ref_crc(pl, pl.size());
        f.push_back(c[7:0]); f.push_back(c[15:8]); f.push_back(c[23:16]); f.push_back(c[31:24]);
        if (flip_at >= 0) f[flip_at] = f[flip_at] ^ 8'h10;
        if (sof_alone) tick(1, 0, 0, 8'hA5, tag);
        for (int i = 0; i < f.size(); i++) begin
            if (gaps && (i % 3 == 1)) tick(0, 0, 0, 8'h5A ^ i[7:0], tag);
            tick(!sof_alone && i == 0, 1, i == f.size() - 1, f[i], tag);
        end
    endtask

    function automatic void mk(ref byte unsigned q[$], input int n, input int k);
        q.delete();
        for (int i = 0; i < n; i++) q.push_back(byte'(i * 37 + k * 11 + 3));
    endfunction

    initial begin
        byte unsigned pl[$];
        rst = 1; sof_i = 0; valid_i = 0; eof_i = 0; data_i = 0;
        repeat (3) @(negedge clk);
        check("R1", frame_done_o, 1'b0, "done in reset");
        check("R1", crc_err_o, 1'b0, "err in reset");
        rst = 0;
        tick(0, 0, 0, 8'h00, "R1");

        // R3 R2: good 18-byte payload, start on the first byte
        mk(pl, 18, 1); send(pl, -1, 0, 0, "R3");
        // R2: start as a separate pulse
        mk(pl, 18, 2); send(pl, -1, 0, 1, "R2");
        // R4: gaps with junk data
        mk(pl, 30, 3); send(pl, -1, 1, 0, "R4");
        // R6: corrupted payload byte, then corrupted check byte
        mk(pl, 20, 4); send(pl, 5, 0, 0, "R6");
        // R7 R9: flag holds through idle and stray end/valid
        repeat (4) tick(0, 0, 0, 8'h00, "R7");
        tick(0, 1, 1, 8'h33, "R9");
        tick(0, 1, 0, 8'h44, "R9");
        tick(0, 0, 1, 8'h55, "R9");
        mk(pl, 16, 5); send(pl, 18, 0, 1, "R6");
        // R7: a start clears the flag
        tick(1, 0, 0, 8'h00, "R7");
        tick(0, 0, 0, 8'h00, "R7");
        // R8: abandoned partial frame, then a good one
        for (int i = 0; i < 7; i++) tick(i == 0, 1, 0, byte'(i * 13), "R8");
        mk(pl, 22, 6); send(pl, -1, 0, 0, "R8");
        // R9: end-of-frame with valid low inside a frame is ignored
        mk(pl, 12, 7);
        begin
            byte unsigned f[$];
            logic [31:0] c;
            f = pl; c = ref_crc(pl, pl.size());
            f.push_back(c[7:0]); f.push_back(c[15:8]); f.push_back(c[23:16]); f.push_back(c[31:24]);
            for (int i = 0; i < f.size(); i++) begin
                if (i == 4) tick(0, 0, 1, 8'hEE, "R9");
                tick(i == 0, 1, i == f.size() - 1, f[i], "R9");
            end
        end
        // R10: start and end together, then finish a good frame
        tick(1, 1, 0, 8'h01, "R10");
        tick(0, 1, 0, 8'h02, "R10");
        mk(pl, 10, 8);
        tick(1, 1, 1, pl[0], "R10");
        begin
            logic [31:0] c;
            c = ref_crc(pl, pl.size());
            for (int i = 1; i < pl.size(); i++) tick(0, 1, 0, pl[i], "R10");
            tick(0, 1, 0, c[7:0], "R10");  tick(0, 1, 0, c[15:8], "R10");
            tick(0, 1, 0, c[23:16], "R10"); tick(0, 1, 1, c[31:24], "R10");
        end
        // R5 R3: long frame, back-to-back with a short one
        mk(pl, 64, 9); send(pl, -1, 0, 0, "R5");
        mk(pl, 1, 10); send(pl, -1, 0, 0, "R5");
        repeat (3) tick(0, 0, 0, 8'h00, "R5");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule